// File: doc/BRIEF.md
# SPI NOR Programmable Command Shifter

This block lets software push an arbitrary serial command frame to a SPI NOR flash and collect whatever the flash returns. Software fills a bank of outgoing byte registers and a bit-count register over a byte-wide register port, then writes a command code. The engine drops chip select, clocks the requested number of bits out on a single MOSI lane (highest-index byte first, MSB first within each byte), shifts every MISO bit into a chain of capture registers, and releases chip select when done.

Besides the free-form frame, two canned commands build their own frames: a flash status read, which returns its byte in a dedicated readback register, and a flash status write, which sends the byte held in the top outgoing register. Nothing is accepted until a protection register holds the unlock value, and a command written during a running frame is dropped. Reads of the register port are combinational; writes take effect on the rising clock edge.

Register map (5-bit address): 0x00 command, 0x01 bit count, 0x02 status readback, 0x03 protection, 0x08+i outgoing byte i (i = 0..5), 0x10+i capture byte i (i = 0..5).

Top module: `spinor_cmd_shifter`

## Requirements
- R1: After reset chip select is high, SCK and MOSI are low, busy is low, and every readable register (command, count, status, protection, outgoing and capture bytes) reads 0.
- R2: A command write is ignored unless the protection register at 0x03 was last written with 0x30 (it then reads back 0x30, otherwise 0); writing any other value locks again. Codes other than 0x02, 0x04 and 0x20 are ignored.
- R3: Code 0x04 with a count of 8 sends only the outgoing byte at 0x0D (byte 5), MSB first, with exactly 8 SCK pulses.
- R4: Code 0x04 with a count of 32 sends bytes 5, 4, 3, 2 (addresses 0x0D, 0x0C, 0x0B, 0x0A) in that order, MSB first; a count of 48 sends all six bytes, 5 down to 0.
- R5: While a frame runs, busy is high and address 0x00 reads the running code; both return to 0 in the cycle chip select rises.
- R6: A frame of N bits holds chip select low for exactly 2N+2 clock cycles; SCK is high only while chip select is low, and each SCK rise is preceded by at least one cycle of chip select low.
- R7: MISO is sampled once per bit at the SCK rise into a 48-bit shift chain; capture byte 0 (0x10) holds the last 8 bits received, byte 1 the 8 before, and so on. A 32-bit frame with opcode 0x9F leaves the three ID bytes in capture bytes 2, 1, 0, first-received in byte 2.
- R8: Code 0x02 sends opcode 0x05 followed by 8 more clocks (16 bits total, count ignored) and leaves the second received byte in the status readback register at 0x02.
- R9: Code 0x20 sends opcode 0x01 followed by outgoing byte 5, 16 bits total, regardless of the count register.
- R10: A command written while busy is ignored: the running frame and its code are unaffected and no second frame follows.
- R11: Code 0x04 with a count of 0 or above 48 completes at once: chip select stays high, SCK never toggles and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK runs at half this rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| busy | output | 1 | High while a frame is in progress |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A corrupted bit counter shows immediately in the number of SCK pulses and in the length of the chip-select window, both counted by the bench on every frame. A wrong shift order or byte selection appears within the first eight SCK rises as a mismatched MOSI word, while a sampling slip or chain misordering lands the flash's response bytes in the wrong capture or status register, visible at the first read after chip select rises. A lost lock or busy guard shows as a frame starting (chip select falling) one cycle after a command that should have been dropped.

// File: rtl/spinor_cmd_pkg.sv
package spinor_cmd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_state_t;

  // host register addresses
  localparam logic [4:0] ADR_CMD  = 5'h00;
  localparam logic [4:0] ADR_CNT  = 5'h01;
  localparam logic [4:0] ADR_STAT = 5'h02;
  localparam logic [4:0] ADR_LOCK = 5'h03;
  localparam logic [4:0] ADR_TX0  = 5'h08;
  localparam logic [4:0] ADR_RX0  = 5'h10;

  // command codes and constants
  localparam logic [7:0] CODE_PROG  = 8'h04;
  localparam logic [7:0] CODE_RDST  = 8'h02;
  localparam logic [7:0] CODE_WRST  = 8'h20;
  localparam logic [7:0] UNLOCK_KEY = 8'h30;
  localparam logic [7:0] OP_RDST    = 8'h05;
  localparam logic [7:0] OP_WRST    = 8'h01;

  // number of bits a command clocks; 0 means the command does nothing
  function automatic logic [7:0] frame_len(input logic [7:0] code,
                                           input logic [7:0] cnt,
                                           input logic [7:0] max_bits);
    case (code)
      CODE_PROG: frame_len = (cnt == 8'd0 || cnt > max_bits) ? 8'd0 : cnt;
      CODE_RDST: frame_len = 8'd16;
      CODE_WRST: frame_len = 8'd16;
      default:   frame_len = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/spinor_host_regs.sv
module spinor_host_regs
  import spinor_cmd_pkg::*;
#(
  parameter int NBYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [4:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [4:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [8*NBYTES-1:0]   tx_bytes,
  output logic [7:0]            bit_count,
  output logic                  lock_open,
  output logic                  cmd_write,
  output logic [7:0]            cmd_code,
  input  logic [8*NBYTES-1:0]   rx_chain,
  input  logic [7:0]            status_byte,
  input  logic [7:0]            active_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_count <= 8'd0;
      lock_open <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CNT)  bit_count <= wr_data;
      if (wr_addr == ADR_LOCK) lock_open <= (wr_data == UNLOCK_KEY);
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_tx
    localparam logic [4:0] MY_ADR = 5'(ADR_TX0 + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tx_bytes[8*i +: 8] <= 8'd0;
      else if (wr_en && wr_addr == MY_ADR)   tx_bytes[8*i +: 8] <= wr_data;
    end
  end

  assign cmd_write = wr_en && (wr_addr == ADR_CMD);
  assign cmd_code  = wr_data;

  always_comb begin
    rd_data = 8'd0;
    case (rd_addr)
      ADR_CMD:  rd_data = active_code;
      ADR_CNT:  rd_data = bit_count;
      ADR_STAT: rd_data = status_byte;
      ADR_LOCK: rd_data = lock_open ? UNLOCK_KEY : 8'd0;
      default:  rd_data = 8'd0;
    endcase
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_addr == 5'(ADR_TX0 + i)) rd_data = tx_bytes[8*i +: 8];
      if (rd_addr == 5'(ADR_RX0 + i)) rd_data = rx_chain[8*i +: 8];
    end
  end

endmodule

// File: rtl/spinor_frame_engine.sv
module spinor_frame_engine
  import spinor_cmd_pkg::*;
#(
  parameter int NBYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_write,
  input  logic [7:0]            cmd_code,
  input  logic                  lock_open,
  input  logic [7:0]            bit_count,
  input  logic [8*NBYTES-1:0]   tx_bytes,
  input  logic                  miso,
  output logic                  cs_n,
  output logic                  sck,
  output logic                  mosi,
  output logic                  busy,
  output logic [7:0]            active_code,
  output logic [8*NBYTES-1:0]   rx_chain,
  output logic [7:0]            status_byte,
  output logic                  frame_start,
  output logic                  bit_sample,
  output logic                  frame_done
);

  localparam int         FRAME_W = 8 * NBYTES;
  localparam logic [7:0] MAX_BITS = 8'(FRAME_W);

  // outgoing image: MSB of the result leaves first
  function automatic logic [FRAME_W-1:0] frame_image(input logic [7:0] code,
                                                     input logic [FRAME_W-1:0] tx);
    case (code)
      CODE_RDST: frame_image = {OP_RDST, {(FRAME_W-8){1'b0}}};
      CODE_WRST: frame_image = {OP_WRST, tx[FRAME_W-1 -: 8], {(FRAME_W-16){1'b0}}};
      default:   frame_image = tx;
    endcase
  endfunction

  eng_state_t         state;
  logic               phase;
  logic [7:0]         bits_left;
  logic [FRAME_W-1:0] shreg;
  logic [7:0]         req_len;

  assign req_len     = frame_len(cmd_code, bit_count, MAX_BITS);
  assign busy        = (state != ST_IDLE);
  assign frame_start = cmd_write && lock_open && !busy && (req_len != 8'd0);
  assign bit_sample  = (state == ST_SHIFT) && !phase;
  assign frame_done  = (state == ST_TRAIL);
  assign cs_n        = (state == ST_IDLE);
  assign sck         = (state == ST_SHIFT) && phase;
  assign mosi        = (state == ST_SHIFT) && shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      phase       <= 1'b0;
      bits_left   <= 8'd0;
      shreg       <= '0;
      rx_chain    <= '0;
      active_code <= 8'd0;
      status_byte <= 8'd0;
    end else begin
      case (state)
        ST_IDLE: if (frame_start) begin
          state       <= ST_LEAD;
          shreg       <= frame_image(cmd_code, tx_bytes);
          bits_left   <= req_len;
          active_code <= cmd_code;
        end
        ST_LEAD: begin
          state <= ST_SHIFT;
          phase <= 1'b0;
        end
        ST_SHIFT: begin
          if (!phase) begin
            phase    <= 1'b1;
            rx_chain <= {rx_chain[FRAME_W-2:0], miso};
          end else begin
            phase     <= 1'b0;
            shreg     <= {shreg[FRAME_W-2:0], 1'b0};
            bits_left <= bits_left - 8'd1;
            if (bits_left == 8'd1) state <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          state       <= ST_IDLE;
          active_code <= 8'd0;
          if (active_code == CODE_RDST) status_byte <= rx_chain[7:0];
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spinor_cmd_shifter.sv
module spinor_cmd_shifter
  import spinor_cmd_pkg::*;
#(
  parameter int NBYTES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int FRAME_W = 8 * NBYTES;

  logic [FRAME_W-1:0] tx_bytes;
  logic [FRAME_W-1:0] rx_chain;
  logic [7:0]         bit_count;
  logic               lock_open;
  logic               cmd_write;
  logic [7:0]         cmd_code;
  logic [7:0]         status_byte;
  logic [7:0]         active_code;
  logic               frame_start;
  logic               bit_sample;
  logic               frame_done;

  spinor_host_regs #(.NBYTES(NBYTES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .tx_bytes    (tx_bytes),
    .bit_count   (bit_count),
    .lock_open   (lock_open),
    .cmd_write   (cmd_write),
    .cmd_code    (cmd_code),
    .rx_chain    (rx_chain),
    .status_byte (status_byte),
    .active_code (active_code)
  );

  spinor_frame_engine #(.NBYTES(NBYTES)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_write   (cmd_write),
    .cmd_code    (cmd_code),
    .lock_open   (lock_open),
    .bit_count   (bit_count),
    .tx_bytes    (tx_bytes),
    .miso        (spi_miso),
    .cs_n        (spi_cs_n),
    .sck         (spi_sck),
    .mosi        (spi_mosi),
    .busy        (busy),
    .active_code (active_code),
    .rx_chain    (rx_chain),
    .status_byte (status_byte),
    .frame_start (frame_start),
    .bit_sample  (bit_sample),
    .frame_done  (frame_done)
  );

endmodule

// File: rtl/spinor_cmd_shifter_chk.sv
module spinor_cmd_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       busy,
  input logic       cmd_write,
  input logic       lock_open,
  input logic       frame_start,
  input logic       bit_sample,
  input logic       frame_done,
  input logic [7:0] active_code
);

  assert_sck_inside_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (!cs_n && $past(!cs_n)));

  assert_sample_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_sample |-> (!sck && !cs_n));

  assert_locked_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && !lock_open && !busy) |=> cs_n);

  assert_release_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!busy && cs_n && active_code == 8'd0));

  assert_code_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(active_code));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !frame_start);

endmodule

bind spinor_cmd_shifter spinor_cmd_shifter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (spi_cs_n),
  .sck         (spi_sck),
  .busy        (busy),
  .cmd_write   (cmd_write),
  .lock_open   (lock_open),
  .frame_start (frame_start),
  .bit_sample  (bit_sample),
  .frame_done  (frame_done),
  .active_code (active_code)
);

// File: tb/sim_spinor_cmd_shifter.sv
module sim_spinor_cmd_shifter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = 5'd0;
  logic [7:0] wr_data = 8'd0;
  logic [4:0] rd_addr = 5'd0;
  logic [7:0] rd_data;
  logic       busy;
  logic       spi_cs_n;
  logic       spi_sck;
  logic       spi_mosi;
  logic       spi_miso;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // flash model state
  logic [63:0] resp = 64'd0;
  int          ridx = 0;
  logic [63:0] mosi_log = 64'd0;
  int          sck_rises = 0;
  int          cs_low = 0;

  always #5 clk = ~clk;

  spinor_cmd_shifter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  assign spi_miso = resp[63 - ridx];

  always @(negedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) ridx = 0;
    else          ridx = ridx + 1;
  end

  always @(posedge spi_sck) begin
    mosi_log  = {mosi_log[62:0], spi_mosi};
    sck_rises = sck_rises + 1;
  end

  always @(negedge clk) if (!spi_cs_n) cs_low = cs_low + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic clear_log();
    mosi_log = 64'd0; sck_rises = 0; cs_low = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] code);
    clear_log();
    wr(5'h00, code);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0 && busy == 1'b0,
          "R1 pins", {spi_cs_n, spi_sck, spi_mosi, busy}, 4'b1000);
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), v);
      check(v == 8'd0, "R1 register", v, 0);
    end
  endtask

  task automatic t_lock();
    wr(5'h01, 8'd8); wr(5'h0D, 8'h06);
    run_cmd(8'h04);
    check(sck_rises == 0 && cs_low == 0, "R2 locked", sck_rises, 0);
    wr(5'h03, 8'h30);
    wr(5'h03, 8'h31);
    run_cmd(8'h04);
    check(sck_rises == 0 && cs_low == 0, "R2 relocked", sck_rises, 0);
    wr(5'h03, 8'h30);
    run_cmd(8'h10);
    check(sck_rises == 0 && cs_low == 0, "R2 unknown code", sck_rises, 0);
  endtask

  task automatic t_opcode_only();
    wr(5'h01, 8'd8); wr(5'h0D, 8'h06); wr(5'h0C, 8'hFF);
    run_cmd(8'h04);
    check(sck_rises == 8, "R3 clocks", sck_rises, 8);
    check(mosi_log[7:0] == 8'h06, "R3 bits", mosi_log[7:0], 8'h06);
    check(cs_low == 18, "R6 window 8", cs_low, 18);
  endtask

  task automatic t_address();
    wr(5'h01, 8'd32);
    wr(5'h0D, 8'h02); wr(5'h0C, 8'h12); wr(5'h0B, 8'h34); wr(5'h0A, 8'h56);
    run_cmd(8'h04);
    check(sck_rises == 32, "R4 clocks", sck_rises, 32);
    check(mosi_log[31:0] == 32'h02123456, "R4 order", mosi_log[31:0], 32'h02123456);
    check(cs_low == 66, "R6 window 32", cs_low, 66);
    wr(5'h09, 8'h9A); wr(5'h08, 8'hBC); wr(5'h01, 8'd48);
    run_cmd(8'h04);
    check(sck_rises == 48 && mosi_log[47:0] == 48'h021234569ABC, "R4 full 48",
          mosi_log[47:0], 48'h021234569ABC);
  endtask

  task automatic t_busy_readback();
    logic [7:0] v;
    wr(5'h01, 8'd8);
    clear_log();
    wr(5'h00, 8'h04);
    rd(5'h00, v);
    check(busy == 1'b1 && v == 8'h04, "R5 running code", v, 8'h04);
    wait_idle();
    rd(5'h00, v);
    check(busy == 1'b0 && v == 8'h00 && spi_cs_n, "R5 cleared", v, 0);
  endtask

  task automatic t_jedec();
    logic [7:0] b2, b1, b0;
    resp = {8'h00, 8'hC2, 8'h20, 8'h17, 32'd0};
    wr(5'h01, 8'd32); wr(5'h0D, 8'h9F);
    run_cmd(8'h04);
    rd(5'h12, b2); rd(5'h11, b1); rd(5'h10, b0);
    check({b2, b1, b0} == 24'hC22017, "R7 id bytes", {b2, b1, b0}, 24'hC22017);
    check(mosi_log[31:24] == 8'h9F, "R7 opcode", mosi_log[31:24], 8'h9F);
    resp = 64'd0;
  endtask

  task automatic t_status_read();
    logic [7:0] v;
    resp = {8'hFF, 8'h5A, 48'd0};
    wr(5'h01, 8'd40);
    run_cmd(8'h02);
    rd(5'h02, v);
    check(v == 8'h5A, "R8 status byte", v, 8'h5A);
    check(sck_rises == 16 && mosi_log[15:0] == 16'h0500, "R8 frame",
          mosi_log[15:0], 16'h0500);
    resp = 64'd0;
  endtask

  task automatic t_status_write();
    wr(5'h01, 8'd8); wr(5'h0D, 8'hA3);
    run_cmd(8'h20);
    check(sck_rises == 16, "R9 clocks", sck_rises, 16);
    check(mosi_log[15:0] == 16'h01A3, "R9 bits", mosi_log[15:0], 16'h01A3);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    wr(5'h01, 8'd8); wr(5'h0D, 8'h66);
    clear_log();
    wr(5'h00, 8'h04);
    repeat (3) @(negedge clk);
    wr(5'h00, 8'h20);
    rd(5'h00, v);
    check(v == 8'h04, "R10 code kept", v, 8'h04);
    wait_idle();
    repeat (10) @(negedge clk);
    check(sck_rises == 8 && mosi_log[7:0] == 8'h66, "R10 single frame",
          sck_rises, 8);
  endtask

  task automatic t_bad_count();
    wr(5'h01, 8'd0);
    run_cmd(8'h04);
    check(sck_rises == 0 && cs_low == 0, "R11 zero count", sck_rises, 0);
    wr(5'h01, 8'd49);
    run_cmd(8'h04);
    check(sck_rises == 0 && cs_low == 0, "R11 count 49", sck_rises, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_opcode_only();
    t_address();
    t_busy_readback();
    t_jedec();
    t_status_read();
    t_status_write();
    t_busy_ignore();
    t_bad_count();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

endmodule